// File: doc/BRIEF.md
# Real-Time Clock Register Access Controller

This block stands between a byte-wide register bus and the BCD timekeeping counters of a real-time clock. Software reads the time from a bank of holding bytes instead of from the live counters. It can freeze that bank to get a consistent snapshot. It can also open the bank for writing, stage a new base time, and have the counters loaded with it as a single one-cycle strobe.

One control byte holds three control bits: a read-hold bit, a write-enable bit and a calibration bit. The same byte holds four status flags. Three of the flags (watchdog expiry, alarm match, supply failure) are set by event pulses and cleared when the byte is read. The fourth flag reports an oscillator that did not start after power-up, and only software can clear it. When calibration is on, the interrupt pin carries a square wave derived from a 32768 Hz tick enable. Otherwise the pin passes the ordinary interrupt request through.

The bus map is as follows. Addresses 0 to NTIME-1 select the time bytes, with the last of them being the BCD centuries byte. Address NTIME selects the control byte. The remaining addresses read as zero.

Top module: `rtc_access_ctrl`

## Requirements
- R1: After reset, the read-hold, write-enable and calibration bits and the watchdog, alarm and supply flags are 0. bus_rdata is 0, load_stb is 0, and int_out equals irq_req.
- R2: A read strobe returns data on bus_rdata in the cycle after the strobe. Address NTIME returns the control byte with bit 7 watchdog flag, bit 6 alarm flag, bit 5 supply flag, bit 4 oscillator flag, bit 3 zero, bit 2 calibration, bit 1 write-enable and bit 0 read-hold. Addresses above NTIME return 0.
- R3: While read-hold and write-enable are both 0, the holding byte at address i follows byte i of live_time, one cycle late.
- R4: Setting read-hold to 1 captures live_time into the holding bytes. Later changes of live_time are not seen until read-hold returns to 0.
- R5: Writes to time addresses take effect only while write-enable is already 1 before the write. Other time writes leave the holding bytes unchanged. While write-enable is 1, live_time is not followed.
- R6: A write to the centuries byte (address NTIME-1) with either nibble above 9 is ignored.
- R7: A control write that clears write-enable after at least one accepted time write raises load_stb for exactly the one cycle after that write. load_time then carries the staged bytes, byte i at bits 8i+7..8i.
- R8: A pulse on wdog_expire, alarm_match or pfail_det sets its flag. A read of the control byte returns the flags as they were and then clears these three. An event in the same cycle as that read leaves its flag set.
- R9: Writes to bits 7, 6 and 5 of the control byte have no effect. Writing 0 to bit 4 clears the oscillator flag only if write-enable was 1 before the write. Writing 1 to bit 4 never sets it.
- R10: If osc_enabled is 1 and osc_running is never 1 during the first STARTUP_CYC cycles after reset, the oscillator flag is set at the end of that window. Otherwise it stays 0.
- R11: With calibration 1, int_out starts low and toggles after every HALF_TICKS tick_32k pulses (default 32, giving 512 Hz). With calibration 0, int_out equals irq_req.
- R12: A write-enable drop with no accepted time write since write-enable was set produces no load_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| live_time | input | NTIME*8 | Current BCD counter bytes |
| pfail_det | input | 1 | Supply failure event pulse |
| wdog_expire | input | 1 | Watchdog expiry pulse |
| alarm_match | input | 1 | Alarm match pulse |
| osc_enabled | input | 1 | Oscillator enable setting |
| osc_running | input | 1 | Oscillator running indicator |
| tick_32k | input | 1 | 32768 Hz clock enable |
| irq_req | input | 1 | Ordinary interrupt request |
| load_stb | output | 1 | One-cycle counter load strobe |
| load_time | output | NTIME*8 | Base time for the counters |
| int_out | output | 1 | Interrupt pin drive |

## Verification
The key collision is a flag event that arrives in the same cycle as a read of the control byte. The read must report the old flag state, and the new event must not be lost to the clear. The bench provokes this by raising wdog_expire on the exact cycle of a read strobe right after a clearing read. It expects 0 in bit 7 from that read and 1 from the next one. A second overlap happens at the write-enable drop, where the load capture and the end of the freeze fall on the same edge. Random staging rounds check that load_time equals the bench's own staged model at that edge.

// File: rtl/rtc_acc_pkg.sv
package rtc_acc_pkg;
  localparam int BIT_R    = 0;
  localparam int BIT_W    = 1;
  localparam int BIT_CAL  = 2;
  localparam int BIT_OSCF = 4;
  localparam int BIT_PF   = 5;
  localparam int BIT_AF   = 6;
  localparam int BIT_WDF  = 7;

  // both nibbles of a BCD byte are decimal digits
  function automatic logic bcd_valid(input logic [7:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  // assemble the control/status byte
  function automatic logic [7:0] pack_ctrl(input logic wdf, input logic af,
                                           input logic pf, input logic oscf,
                                           input logic cal, input logic w,
                                           input logic r);
    return {wdf, af, pf, oscf, 1'b0, cal, w, r};
  endfunction
endpackage

// File: rtl/rtc_hold_bank.sv
module rtc_hold_bank #(
  parameter int NTIME = 8,
  localparam int IW = $clog2(NTIME)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               track,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [7:0]         wr_byte,
  input  logic [NTIME*8-1:0] live_time,
  input  logic               w_fall,
  input  logic [IW-1:0]      rd_idx,
  output logic [7:0]         rd_byte,
  output logic               load_stb,
  output logic [NTIME*8-1:0] load_time,
  output logic [NTIME*8-1:0] hold_flat
);
  logic [7:0] hold_q [NTIME];
  logic       dirty_q;

  for (genvar i = 0; i < NTIME; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hold_q[i] <= '0;
      else if (wr_en && (wr_idx == IW'(i)))
        hold_q[i] <= wr_byte;
      else if (track)
        hold_q[i] <= live_time[i*8 +: 8];
    end
    assign hold_flat[i*8 +: 8] = hold_q[i];
  end

  assign rd_byte = hold_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q   <= 1'b0;
      load_stb  <= 1'b0;
      load_time <= '0;
    end else begin
      load_stb <= w_fall && dirty_q;
      if (w_fall && dirty_q)
        load_time <= hold_flat;
      if (w_fall)
        dirty_q <= 1'b0;
      else if (wr_en)
        dirty_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit #(
  parameter int STARTUP_CYC = 250000,
  localparam int CW = $clog2(STARTUP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdog_expire,
  input  logic alarm_match,
  input  logic pfail_det,
  input  logic osc_enabled,
  input  logic osc_running,
  input  logic flags_rd,
  input  logic oscf_clr,
  output logic wdf,
  output logic af,
  output logic pf,
  output logic oscf
);
  logic [CW-1:0] win_cnt;
  logic          win_done;
  logic          run_seen;

  // event set outranks the read clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdf <= 1'b0;
      af  <= 1'b0;
      pf  <= 1'b0;
    end else begin
      wdf <= wdog_expire || (wdf && !flags_rd);
      af  <= alarm_match || (af && !flags_rd);
      pf  <= pfail_det   || (pf && !flags_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      win_done <= 1'b0;
      run_seen <= 1'b0;
      oscf     <= 1'b0;
    end else begin
      if (!win_done) begin
        run_seen <= run_seen || osc_running;
        if (win_cnt == CW'(STARTUP_CYC - 1)) begin
          win_done <= 1'b1;
          oscf     <= osc_enabled && !(run_seen || osc_running);
        end else begin
          win_cnt <= win_cnt + 1'b1;
        end
      end else if (oscf_clr) begin
        oscf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rtc_cal_div.sv
module rtc_cal_div #(
  parameter int HALF_TICKS = 32,
  localparam int DW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic sq
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sq  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sq  <= 1'b0;
    end else if (tick) begin
      if (cnt == DW'(HALF_TICKS - 1)) begin
        cnt <= '0;
        sq  <= !sq;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_access_ctrl.sv
module rtc_access_ctrl
  import rtc_acc_pkg::*;
#(
  parameter int NTIME       = 8,
  parameter int AW          = 4,
  parameter int STARTUP_CYC = 250000,
  parameter int HALF_TICKS  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [7:0]         bus_rdata,
  input  logic [NTIME*8-1:0] live_time,
  input  logic               pfail_det,
  input  logic               wdog_expire,
  input  logic               alarm_match,
  input  logic               osc_enabled,
  input  logic               osc_running,
  input  logic               tick_32k,
  input  logic               irq_req,
  output logic               load_stb,
  output logic [NTIME*8-1:0] load_time,
  output logic               int_out
);
  localparam int IW = $clog2(NTIME);
  localparam logic [AW-1:0] CTRL_A = AW'(NTIME);
  localparam logic [AW-1:0] CENT_A = AW'(NTIME - 1);

  logic r_q, w_q, cal_q;
  logic wdf, af, pf, oscf;
  logic cal_sq;
  logic [7:0] hold_byte;
  logic [NTIME*8-1:0] hold_flat;

  // named internal events
  logic wr_ctrl, rd_ctrl, time_sel, time_wr_ok, w_fall, oscf_clr, track;

  assign wr_ctrl    = bus_wr && (bus_addr == CTRL_A);
  assign rd_ctrl    = bus_rd && (bus_addr == CTRL_A);
  assign time_sel   = bus_addr < CTRL_A;
  assign time_wr_ok = bus_wr && time_sel && w_q &&
                      ((bus_addr != CENT_A) || bcd_valid(bus_wdata));
  assign w_fall     = wr_ctrl && w_q && !bus_wdata[BIT_W];
  assign oscf_clr   = wr_ctrl && w_q && !bus_wdata[BIT_OSCF];
  assign track      = !r_q && !w_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q   <= 1'b0;
      w_q   <= 1'b0;
      cal_q <= 1'b0;
    end else if (wr_ctrl) begin
      r_q   <= bus_wdata[BIT_R];
      w_q   <= bus_wdata[BIT_W];
      cal_q <= bus_wdata[BIT_CAL];
    end
  end

  rtc_hold_bank #(.NTIME(NTIME)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .track     (track),
    .wr_en     (time_wr_ok),
    .wr_idx    (bus_addr[IW-1:0]),
    .wr_byte   (bus_wdata),
    .live_time (live_time),
    .w_fall    (w_fall),
    .rd_idx    (bus_addr[IW-1:0]),
    .rd_byte   (hold_byte),
    .load_stb  (load_stb),
    .load_time (load_time),
    .hold_flat (hold_flat)
  );

  rtc_flag_unit #(.STARTUP_CYC(STARTUP_CYC)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdog_expire (wdog_expire),
    .alarm_match (alarm_match),
    .pfail_det   (pfail_det),
    .osc_enabled (osc_enabled),
    .osc_running (osc_running),
    .flags_rd    (rd_ctrl),
    .oscf_clr    (oscf_clr),
    .wdf         (wdf),
    .af          (af),
    .pf          (pf),
    .oscf        (oscf)
  );

  rtc_cal_div #(.HALF_TICKS(HALF_TICKS)) u_cal (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (cal_q),
    .tick  (tick_32k),
    .sq    (cal_sq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd) begin
      if (time_sel)
        bus_rdata <= hold_byte;
      else if (bus_addr == CTRL_A)
        bus_rdata <= pack_ctrl(wdf, af, pf, oscf, cal_q, w_q, r_q);
      else
        bus_rdata <= '0;
    end
  end

  assign int_out = cal_q ? cal_sq : irq_req;
endmodule

// File: rtl/rtc_access_ctrl_chk.sv
module rtc_access_ctrl_chk #(
  parameter int NTIME = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load_stb,
  input logic               w_fall,
  input logic               wdog_expire,
  input logic               alarm_match,
  input logic               pfail_det,
  input logic               rd_ctrl,
  input logic               wdf,
  input logic               af,
  input logic               pf,
  input logic               r_q,
  input logic               w_q,
  input logic               cal_q,
  input logic               cal_sq,
  input logic [NTIME*8-1:0] hold_flat
);
  // R7
  load_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  // R7
  load_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(w_fall));

  // R8
  wdf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_expire |=> wdf);

  // R8
  af_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_match |=> af);

  // R8
  pf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfail_det |=> pf);

  // R8
  wdf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !wdog_expire) |=> !wdf);

  // R4
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_q && !w_q) |=> $stable(hold_flat));

  // R11
  cal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_q |=> !cal_sq);
endmodule

bind rtc_access_ctrl rtc_access_ctrl_chk #(.NTIME(NTIME)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_stb    (load_stb),
  .w_fall      (w_fall),
  .wdog_expire (wdog_expire),
  .alarm_match (alarm_match),
  .pfail_det   (pfail_det),
  .rd_ctrl     (rd_ctrl),
  .wdf         (wdf),
  .af          (af),
  .pf          (pf),
  .r_q         (r_q),
  .w_q         (w_q),
  .cal_q       (cal_q),
  .cal_sq      (cal_sq),
  .hold_flat   (hold_flat)
);

// File: tb/rtc_access_ctrl_test.sv
`timescale 1ns/1ps
module rtc_access_ctrl_test;
  localparam int NT = 8;
  localparam int AW = 4;
  localparam int WIN = 40;
  localparam int HALF = 32;
  localparam logic [3:0] CA = 4'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [NT*8-1:0] live = '0;
  logic pfail_det = 1'b0, wdog_expire = 1'b0, alarm_match = 1'b0;
  logic osc_enabled = 1'b1, osc_running = 1'b1;
  logic tick_32k = 1'b0, irq_req = 1'b0;
  logic load_stb, int_out;
  logic [NT*8-1:0] load_time;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rtc_access_ctrl #(.NTIME(NT), .AW(AW), .STARTUP_CYC(WIN), .HALF_TICKS(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .live_time(live),
    .pfail_det(pfail_det), .wdog_expire(wdog_expire), .alarm_match(alarm_match),
    .osc_enabled(osc_enabled), .osc_running(osc_running), .tick_32k(tick_32k),
    .irq_req(irq_req), .load_stb(load_stb), .load_time(load_time), .int_out(int_out)
  );

  function automatic logic [7:0] ctl(input logic wdf, input logic af, input logic pf,
                                     input logic osc, input logic cal, input logic w,
                                     input logic r);
    logic [7:0] b;
    b = 8'h00;
    b[7] = wdf; b[6] = af; b[5] = pf; b[4] = osc;
    b[2] = cal; b[1] = w; b[0] = r;
    return b;
  endfunction

  function automatic logic [7:0] rbcd();
    logic [3:0] hi, lo;
    hi = 4'($urandom_range(9));
    lo = 4'($urandom_range(9));
    return {hi, lo};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic run);
    @(negedge clk);
    rst_n = 1'b0;
    osc_running = run;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_32k = 1'b1;
    @(negedge clk);
    tick_32k = 1'b0;
  endtask

  task automatic pulse_evt(input int which);
    @(negedge clk);
    if (which == 0) wdog_expire = 1'b1;
    if (which == 1) alarm_match = 1'b1;
    if (which == 2) pfail_det = 1'b1;
    @(negedge clk);
    wdog_expire = 1'b0; alarm_match = 1'b0; pfail_det = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] stg [NT];
    logic [NT*8-1:0] old_live, exp_ld;
    void'($urandom(32'd2024));

    // R1 reset state
    irq_req = 1'b1;
    do_reset(1'b1);
    @(negedge clk);
    check("R1 rdata", bus_rdata, 0);
    check("R1 load_stb", load_stb, 0);
    check("R1 int_out follows irq", int_out, 1);
    irq_req = 1'b0;
    repeat (WIN + 5) @(negedge clk);
    rd(CA, d);
    check("R1 R10 ctrl after reset, osc running", d, 8'h00);

    // R3 tracking and R2 map
    live = 64'h19_12_31_07_23_59_58_57;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NT; i++) begin
      rd(4'(i), d);
      check("R3 live byte", d, live[i*8 +: 8]);
    end
    rd(4'd12, d);
    check("R2 unused address", d, 8'h00);

    // R4 read-hold
    old_live = live;
    wr(CA, 8'h01);
    live = 64'h20_01_01_01_00_00_00_11;
    repeat (3) @(negedge clk);
    rd(4'd0, d);
    check("R4 frozen byte0", d, old_live[7:0]);
    rd(CA, d);
    check("R2 ctrl layout R bit", d, ctl(0,0,0,0,0,0,1));
    // R5 write without W ignored
    wr(4'd0, 8'h55);
    rd(4'd0, d);
    check("R5 write with W=0 ignored", d, old_live[7:0]);
    wr(CA, 8'h00);
    repeat (2) @(negedge clk);
    rd(4'd0, d);
    check("R4 resume after R=0", d, live[7:0]);

    // R5 R6 R7 directed staging
    wr(CA, 8'h02);
    old_live = live;
    live = 64'h99_99_99_99_99_99_99_99;
    wr(4'd0, 8'h42);
    rd(4'd0, d);
    check("R5 staged write", d, 8'h42);
    rd(4'd1, d);
    check("R5 no tracking under W", d, old_live[15:8]);
    wr(4'd7, 8'h9A);
    rd(4'd7, d);
    check("R6 bad BCD centuries ignored", d, old_live[63:56]);
    wr(4'd7, 8'h19);
    rd(4'd7, d);
    check("R6 good BCD centuries", d, 8'h19);
    exp_ld = {8'h19, old_live[55:8], 8'h42};
    wr(CA, 8'h00);
    check("R7 load strobe", load_stb, 1);
    check("R7 load value", load_time, exp_ld);
    @(negedge clk);
    check("R7 strobe one cycle", load_stb, 0);

    // R12 no dirty, no load
    wr(CA, 8'h02);
    wr(CA, 8'h00);
    check("R12 no load when clean", load_stb, 0);
    @(negedge clk);
    check("R12 still no load", load_stb, 0);

    // R8 flags
    for (int k = 0; k < 3; k++) begin
      pulse_evt(k);
      rd(CA, d);
      check("R8 flag set", d, 8'h80 >> k);
      rd(CA, d);
      check("R8 flag cleared by read", d, 8'h00);
    end
    // R8 event in the same cycle as the read
    @(negedge clk);
    bus_addr = CA; bus_rd = 1'b1; wdog_expire = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; wdog_expire = 1'b0;
    check("R8 collide read old", bus_rdata, 8'h00);
    rd(CA, d);
    check("R8 collide flag kept", d, 8'h80);
    rd(CA, d);
    check("R8 collide then clear", d, 8'h00);
    // R9 read-only flag bits
    wr(CA, 8'h02);
    wr(CA, 8'hE2);
    rd(CA, d);
    check("R9 read-only flags", d, 8'h02);
    wr(CA, 8'h00);

    // random staging rounds (R5 R7)
    for (int it = 0; it < 12; it++) begin
      for (int i = 0; i < NT; i++) live[i*8 +: 8] = rbcd();
      repeat (2) @(negedge clk);
      wr(CA, 8'h02);
      for (int i = 0; i < NT; i++) stg[i] = live[i*8 +: 8];
      for (int j = 0; j < 1 + int'($urandom_range(5)); j++) begin
        int a;
        logic [7:0] v;
        a = int'($urandom_range(NT - 1));
        v = rbcd();
        live[7:0] = rbcd();
        wr(4'(a), v);
        stg[a] = v;
      end
      for (int i = 0; i < NT; i++) exp_ld[i*8 +: 8] = stg[i];
      wr(CA, 8'h00);
      check("R7 random load strobe", load_stb, 1);
      check("R7 random load value", load_time, exp_ld);
    end

    // R11 calibration output
    irq_req = 1'b1;
    wr(CA, 8'h04);
    check("R11 cal starts low", int_out, 0);
    for (int t = 0; t < HALF - 1; t++) tick();
    check("R11 before half period", int_out, 0);
    tick();
    check("R11 first toggle", int_out, 1);
    for (int t = 0; t < HALF; t++) tick();
    check("R11 second toggle", int_out, 0);
    rd(CA, d);
    check("R2 R11 ctrl cal bit", d, 8'h04);
    wr(CA, 8'h00);
    check("R11 irq passthrough", int_out, 1);
    irq_req = 1'b0;
    @(negedge clk);
    check("R11 irq passthrough low", int_out, 0);

    // R10 R9 oscillator flag
    do_reset(1'b0);
    repeat (WIN + 5) @(negedge clk);
    rd(CA, d);
    check("R10 osc flag set", d, 8'h10);
    wr(CA, 8'h00);
    rd(CA, d);
    check("R9 osc clear needs W", d, 8'h10);
    wr(CA, 8'h02);
    wr(CA, 8'h12);
    rd(CA, d);
    check("R9 osc write 1 keeps", d, 8'h12);
    wr(CA, 8'h02);
    rd(CA, d);
    check("R9 osc cleared", d, 8'h02);
    wr(CA, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule